// File: doc/BRIEF.md
# Serial Link Endpoint with Acknowledged Byte Transfer

This block is one end of a full-duplex, byte-oriented serial link. It uses one wire in each direction. The outgoing wire carries two kinds of packet: data packets for bytes the local side sends, and acknowledge packets for bytes the local side has received. Bytes to send enter on a valid/ready interface. Each byte is framed and shifted out. The next byte is not accepted until the far end has acknowledged the previous one on the incoming wire.

The incoming wire is asynchronous to the block clock. It passes through a synchronizer and is sampled at the system clock rate. A rising edge from the idle level starts a packet, and each later bit is taken near its centre. The bit after the start bit tells the two packet kinds apart. Received bytes go into a one-byte buffer and leave on a second valid/ready interface. The block sends the acknowledge for an incoming byte as soon as it recognises the packet as data, provided the buffer is free. Otherwise the acknowledge waits until the buffer has been read. This ties the far end's sending rate to local consumption.

A single speed input sets the bit period for both directions at once: `BIT_CLKS` clocks per bit when high, twice that when low.

Top module: `slink_endpoint`

## Requirements
- R1: While no packet is being sent, line_o is low. While rst_ni is low, line_o is low, tx_ready_o is high and rx_valid_o is low.
- R2: A data packet on line_o is, in order: a high start bit, a high marker bit, the eight data bits with bit 0 first, and a low stop bit. Each bit holds for one bit period.
- R3: A data packet on line_i, arriving at any phase relative to the clock, delivers its byte on rx_data_o with rx_valid_o high. The byte stays stable until rx_ready_i accepts it.
- R4: Once a byte has been accepted, tx_ready_o stays low through its transmission and afterwards. It rises only after an acknowledge packet (high then low) has been received on line_i.
- R5: For every data packet received while the buffer is free, an acknowledge packet (high bit, then low bit) goes out on line_o. It starts before the incoming packet has finished.
- R6: If the receive buffer is still occupied when a new data packet is recognised, that packet's acknowledge is withheld until the buffer is read. The new byte is kept and delivered afterwards.
- R7: When an acknowledge and a data byte are both waiting at the end of a packet, the acknowledge is sent first.
- R8: With fast_i high a bit lasts BIT_CLKS clocks, and with fast_i low it lasts 2*BIT_CLKS clocks. The setting applies to sending and receiving alike.
- R9: An acknowledge received when no transmitted byte is awaiting one has no effect. The next byte sent still waits for its own acknowledge, and no packet is emitted in reply.
- R10: Asserting rst_ni low in the middle of a packet drops line_o low at once. No packet resumes after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_i | input | 1 | Bit rate select: 1 short bit period, 0 double period |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | tx_data_i is valid |
| tx_ready_o | output | 1 | Block can take a byte to send |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | rx_data_o holds an unread byte |
| rx_ready_i | input | 1 | Consumer takes the received byte |
| line_i | input | 1 | Incoming serial wire, asynchronous |
| line_o | output | 1 | Outgoing serial wire |

## Verification
The hardest state to reach from the ports is contention on the outgoing wire: an acknowledge and a data byte both ready at the moment a packet ends. The bench gets there in three steps. First it starts a local byte. While that byte is still shifting out, the bench model of the far end sends an early acknowledge, which lets a second byte be accepted and held. Straight after the acknowledge, the far end starts a data packet of its own, and that packet is recognised well before the local frame ends. A second hard case is the withheld acknowledge. Here the consumer keeps the buffer full while the far end, which has legitimately received credit, sends another byte. The bench then confirms that no acknowledge appears until the consumer reads the buffer.

// File: rtl/slink_pkg.sv
package slink_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PKT_MAX = BYTE_W + 3;  // start, marker, byte, stop
  localparam int unsigned ACK_LEN = 2;

  typedef logic [PKT_MAX-1:0] pkt_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_MARK,
    RX_BODY
  } rx_state_e;

  // bit 0 leaves first
  localparam pkt_t ACK_PKT = pkt_t'(2'b01);

  function automatic pkt_t data_pkt(input logic [BYTE_W-1:0] b);
    return {1'b0, b, 2'b11};
  endfunction
endpackage

// File: rtl/slink_rx.sv
module slink_rx
  import slink_pkg::*;
#(
  parameter int unsigned BIT_CLKS    = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_i,
  input  logic              line_i,
  output logic              mark_o,
  output logic              ack_seen_o,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned CW = $clog2(3 * BIT_CLKS + 1);

  logic [SYNC_STAGES:0] sync_q;
  logic                 rx_bit, rx_prev;
  logic [CW-1:0]        bit_len, cnt_q;
  logic [3:0]           bidx_q;
  logic [BYTE_W-1:0]    sh_q;
  rx_state_e            state_q;
  logic                 tick;

  assign rx_bit  = sync_q[SYNC_STAGES-1];
  assign rx_prev = sync_q[SYNC_STAGES];
  assign bit_len = fast_i ? CW'(BIT_CLKS) : CW'(2 * BIT_CLKS);
  assign tick    = (state_q != RX_IDLE) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], line_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
    end else if (state_q == RX_IDLE) begin
      if (rx_bit && !rx_prev) begin
        state_q <= RX_MARK;
        // skip to the centre of the marker bit, minus synchronizer lag
        cnt_q   <= bit_len + (bit_len >> 1) - CW'(2);
      end
    end else if (tick) begin
      cnt_q <= bit_len - CW'(1);
      if (state_q == RX_MARK) begin
        bidx_q  <= '0;
        state_q <= rx_bit ? RX_BODY : RX_IDLE;
      end else begin
        bidx_q <= bidx_q + 4'd1;
        if (bidx_q < 4'(BYTE_W)) sh_q <= {rx_bit, sh_q[BYTE_W-1:1]};
        else                     state_q <= RX_IDLE;  // stop bit centre
      end
    end else begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign mark_o      = tick && (state_q == RX_MARK) && rx_bit;
  assign ack_seen_o  = tick && (state_q == RX_MARK) && !rx_bit;
  assign byte_done_o = tick && (state_q == RX_BODY) && (bidx_q == 4'(BYTE_W));
  assign byte_o      = sh_q;
endmodule

// File: rtl/slink_rxbuf.sv
module slink_rxbuf
  import slink_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mark_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ack_taken_i,
  input  logic              rx_ready_i,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              ack_req_o
);
  logic              owed_q, ack_q, stage_full_q;
  logic [BYTE_W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owed_q       <= 1'b0;
      ack_q        <= 1'b0;
      stage_full_q <= 1'b0;
      stage_q      <= '0;
      rx_valid_o   <= 1'b0;
      rx_data_o    <= '0;
    end else begin
      if (ack_taken_i) ack_q <= 1'b0;
      // credit is granted only while the output buffer is empty
      if (owed_q && !rx_valid_o) begin
        owed_q <= 1'b0;
        ack_q  <= 1'b1;
      end
      if (mark_i) owed_q <= 1'b1;

      if (stage_full_q && !rx_valid_o) begin
        rx_valid_o   <= 1'b1;
        rx_data_o    <= stage_q;
        stage_full_q <= 1'b0;
      end else if (rx_valid_o && rx_ready_i) begin
        rx_valid_o <= 1'b0;
      end
      if (byte_done_i) begin
        stage_full_q <= 1'b1;
        stage_q      <= byte_i;
      end
    end
  end

  assign ack_req_o = ack_q;
endmodule

// File: rtl/slink_tx.sv
module slink_tx
  import slink_pkg::*;
#(
  parameter int unsigned BIT_CLKS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic              ack_req_i,
  input  logic              ack_seen_i,
  output logic              ack_taken_o,
  output logic              line_o
);
  localparam int unsigned CW = $clog2(2 * BIT_CLKS + 1);

  logic              held_q, wait_q, busy_q;
  logic [BYTE_W-1:0] hold_q;
  pkt_t              sreg_q;
  logic [3:0]        left_q;
  logic [CW-1:0]     cnt_q, bit_len;
  logic              bit_end, last_bit, can_load, load_ack, load_data;

  assign bit_len   = fast_i ? CW'(BIT_CLKS) : CW'(2 * BIT_CLKS);
  assign bit_end   = busy_q && (cnt_q == '0);
  assign last_bit  = bit_end && (left_q == 4'd1);
  assign can_load  = !busy_q || last_bit;
  assign load_ack  = can_load && ack_req_i;
  assign load_data = can_load && !ack_req_i && held_q;

  assign tx_ready_o  = !held_q && !wait_q;
  assign ack_taken_o = load_ack;
  assign line_o      = busy_q & sreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      hold_q <= '0;
      wait_q <= 1'b0;
    end else begin
      if (tx_valid_i && tx_ready_o) begin
        held_q <= 1'b1;
        hold_q <= tx_data_i;
      end
      if (ack_seen_i) wait_q <= 1'b0;
      if (load_data) begin
        held_q <= 1'b0;
        wait_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sreg_q <= '0;
      left_q <= '0;
      cnt_q  <= '0;
    end else if (load_ack || load_data) begin
      busy_q <= 1'b1;
      sreg_q <= load_ack ? ACK_PKT : data_pkt(hold_q);
      left_q <= load_ack ? 4'(ACK_LEN) : 4'(PKT_MAX);
      cnt_q  <= bit_len - CW'(1);
    end else if (bit_end) begin
      if (last_bit) begin
        busy_q <= 1'b0;
      end else begin
        sreg_q <= sreg_q >> 1;
        left_q <= left_q - 4'd1;
        cnt_q  <= bit_len - CW'(1);
      end
    end else if (busy_q) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/slink_endpoint.sv
module slink_endpoint
  import slink_pkg::*;
#(
  parameter int unsigned BIT_CLKS    = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic              line_i,
  output logic              line_o
);
  logic              mark, ack_seen, byte_done, ack_req, ack_taken;
  logic [BYTE_W-1:0] rx_byte;

  slink_rx #(.BIT_CLKS(BIT_CLKS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fast_i      (fast_i),
    .line_i      (line_i),
    .mark_o      (mark),
    .ack_seen_o  (ack_seen),
    .byte_done_o (byte_done),
    .byte_o      (rx_byte)
  );

  slink_rxbuf u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mark_i      (mark),
    .byte_done_i (byte_done),
    .byte_i      (rx_byte),
    .ack_taken_i (ack_taken),
    .rx_ready_i  (rx_ready_i),
    .rx_valid_o  (rx_valid_o),
    .rx_data_o   (rx_data_o),
    .ack_req_o   (ack_req)
  );

  slink_tx #(.BIT_CLKS(BIT_CLKS)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fast_i      (fast_i),
    .tx_data_i   (tx_data_i),
    .tx_valid_i  (tx_valid_i),
    .tx_ready_o  (tx_ready_o),
    .ack_req_i   (ack_req),
    .ack_seen_i  (ack_seen),
    .ack_taken_o (ack_taken),
    .line_o      (line_o)
  );
endmodule

module slink_endpoint_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_valid_i,
  input logic       tx_ready_o,
  input logic       rx_valid_o,
  input logic       rx_ready_i,
  input logic [7:0] rx_data_o,
  input logic       line_o,
  input logic       ack_req_i,
  input logic       ack_taken_i,
  input logic       ack_seen_i
);
  a_r4_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && tx_ready_o |=> !tx_ready_o);

  a_r4_ready_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ready_o) |-> $past(ack_seen_i));

  a_r3_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_data_o));

  a_r2_start_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_o) |=> line_o);

  a_r6_ack_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_i && !ack_taken_i |=> ack_req_i);

  a_r5_ack_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_taken_i |=> line_o);
endmodule

bind slink_endpoint slink_endpoint_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_valid_i  (tx_valid_i),
  .tx_ready_o  (tx_ready_o),
  .rx_valid_o  (rx_valid_o),
  .rx_ready_i  (rx_ready_i),
  .rx_data_o   (rx_data_o),
  .line_o      (line_o),
  .ack_req_i   (ack_req),
  .ack_taken_i (ack_taken),
  .ack_seen_i  (ack_seen)
);

// File: tb/sim_slink_endpoint.sv
module sim_slink_endpoint;
  localparam int CLK_PERIOD = 10;
  localparam int BITC       = 5;

  logic       clk = 1'b0;
  logic       rst_n, fast, line_i, line_o;
  logic [7:0] tx_data, rx_data;
  logic       tx_valid, tx_ready, rx_valid, rx_ready;

  int total = 0, bad = 0;
  int cur_l = BITC;

  logic [8:0]  plog [0:63];
  int          pcnt = 0, nack = 0, stop_err = 0;
  time         ack_t = 0, mon_t;
  logic [10:0] mon_f;
  logic        mon_prev, mon_ack;
  logic [7:0]  cap [0:63];
  int          ncap = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  slink_endpoint #(.BIT_CLKS(BITC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fast_i(fast),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .line_i(line_i), .line_o(line_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // decoder of the outgoing wire
  initial begin
    mon_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n) mon_prev = 1'b0;
      else if (line_o && !mon_prev) begin
        mon_t = $time; mon_f = '0; mon_f[0] = 1'b1; mon_ack = 1'b0;
        for (int k = 1; k < 11; k++) begin
          repeat (cur_l) @(negedge clk);
          mon_f[k] = line_o;
          if (k == 1 && !line_o) begin mon_ack = 1'b1; break; end
        end
        if (mon_ack) begin plog[pcnt] = 9'h000; nack++; ack_t = mon_t; end
        else begin
          plog[pcnt] = {1'b1, mon_f[9:2]};
          if (mon_f[10]) stop_err++;
        end
        if (pcnt < 63) pcnt++;
        mon_prev = line_o;
      end else mon_prev = line_o;
    end
  end

  always @(negedge clk)
    if (rst_n && rx_valid && rx_ready && ncap < 64) begin
      cap[ncap] = rx_data;
      ncap++;
    end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1: actual=running expected=finished");
    summary();
    $finish;
  end

  function automatic logic [10:0] dpkt(input logic [7:0] b);
    return {1'b0, b, 2'b11};
  endfunction

  task automatic send_pkt(input logic [10:0] f, input int n, input int phase);
    #(phase);
    for (int i = 0; i < n; i++) begin
      line_i = f[i];
      #(cur_l * CLK_PERIOD);
    end
    line_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic set_rx_ready(input logic v);
    @(posedge clk); #2 rx_ready = v;
  endtask

  task automatic t_reset();
    check("R1 line low in reset", int'(line_o), 0);
    check("R1 tx_ready in reset", int'(tx_ready), 1);
    check("R1 rx_valid in reset", int'(rx_valid), 0);
  endtask

  task automatic t_tx_basic();
    int p0 = pcnt;
    push(8'hA5);
    repeat (11 * cur_l + 8) @(negedge clk);
    check("R2 data frame", int'(plog[p0]), 9'h1A5);
    check("R2 stop bit low", stop_err, 0);
    check("R1 idle low after packet", int'(line_o), 0);
    check("R4 no ready before ack", int'(tx_ready), 0);
    send_pkt(11'b01, 2, 3);
    repeat (3 * cur_l) @(negedge clk);
    check("R4 ready after ack", int'(tx_ready), 1);
  endtask

  task automatic t_rx_basic();
    int a0 = nack, c0 = ncap;
    time t_end;
    send_pkt(dpkt(8'h3C), 11, 7);
    t_end = $time;
    repeat (4 * cur_l) @(negedge clk);
    check("R5 one ack sent", nack - a0, 1);
    check("R5 ack overlaps byte", int'(ack_t < t_end), 1);
    check("R3 byte delivered", ncap - c0, 1);
    check("R3 byte value", int'(cap[c0]), 8'h3C);
  endtask

  task automatic t_rx_backpressure();
    int a0 = nack, c0 = ncap;
    set_rx_ready(1'b0);
    send_pkt(dpkt(8'h11), 11, 4);
    repeat (15) @(negedge clk);
    check("R5 ack for free buffer", nack - a0, 1);
    check("R3 held valid", int'(rx_valid), 1);
    send_pkt(dpkt(8'h22), 11, 2);
    repeat (30) @(negedge clk);
    check("R6 ack withheld", nack - a0, 1);
    check("R6 first byte kept", int'(rx_data), 8'h11);
    set_rx_ready(1'b1);
    repeat (4 * cur_l + 10) @(negedge clk);
    check("R6 ack after read", nack - a0, 2);
    check("R6 both bytes delivered", ncap - c0, 2);
    check("R6 second byte value", int'(cap[c0 + 1]), 8'h22);
  endtask

  task automatic t_ack_priority();
    int p0 = pcnt, c0 = ncap;
    push(8'h5A);
    fork
      push(8'h6B);
      begin
        send_pkt(11'b01, 2, 13);
        send_pkt(dpkt(8'h77), 11, 0);
      end
    join
    repeat (20 * cur_l) @(negedge clk);
    check("R7 first data", int'(plog[p0]), 9'h15A);
    check("R7 ack before data", int'(plog[p0 + 1]), 9'h000);
    check("R7 held data after ack", int'(plog[p0 + 2]), 9'h16B);
    check("R3 overlapped byte", int'(cap[c0]), 8'h77);
    send_pkt(11'b01, 2, 4);
    repeat (3 * cur_l) @(negedge clk);
    check("R4 ready after final ack", int'(tx_ready), 1);
  endtask

  task automatic t_slow();
    int p0 = pcnt, a0 = nack, c0 = ncap;
    @(negedge clk);
    fast = 1'b0; cur_l = 2 * BITC;
    push(8'hC3);
    repeat (11 * cur_l + 8) @(negedge clk);
    check("R8 slow tx frame", int'(plog[p0]), 9'h1C3);
    send_pkt(11'b01, 2, 5);
    send_pkt(dpkt(8'h96), 11, 3);
    repeat (4 * cur_l) @(negedge clk);
    check("R8 slow rx byte", int'(cap[c0]), 8'h96);
    check("R8 slow ack sent", nack - a0, 1);
    check("R8 slow ready back", int'(tx_ready), 1);
    @(negedge clk);
    fast = 1'b1; cur_l = BITC;
  endtask

  task automatic t_stray_ack();
    int p0 = pcnt;
    send_pkt(11'b01, 2, 6);
    repeat (4 * cur_l) @(negedge clk);
    check("R9 ready unchanged", int'(tx_ready), 1);
    check("R9 no reply packet", pcnt - p0, 0);
    push(8'h0F);
    repeat (11 * cur_l + 8) @(negedge clk);
    check("R9 byte still waits", int'(tx_ready), 0);
    send_pkt(11'b01, 2, 2);
    repeat (3 * cur_l) @(negedge clk);
    check("R9 own ack releases", int'(tx_ready), 1);
  endtask

  task automatic t_reset_mid();
    push(8'hFF);
    repeat (3 * cur_l) @(negedge clk);
    check("R10 mid packet high", int'(line_o), 1);
    rst_n = 1'b0;
    #1;
    check("R10 line drops", int'(line_o), 0);
    check("R10 ready restored", int'(tx_ready), 1);
    check("R10 rx empty", int'(rx_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    begin
      int hi = 0;
      for (int i = 0; i < 12 * cur_l; i++) begin
        @(negedge clk);
        if (line_o) hi++;
      end
      check("R10 no resumed packet", hi, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; fast = 1'b1; line_i = 1'b0;
    tx_data = '0; tx_valid = 1'b0; rx_ready = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_tx_basic();
    t_rx_basic();
    t_rx_backpressure();
    t_ack_priority();
    t_slow();
    t_stray_ack();
    t_reset_mid();
    summary();
    $finish;
  end
endmodule